// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

A synthesizable behavioural model of a small single-port synchronous SRAM with two byte lanes, a built-in two-bit burst address counter and a low-power sleep input. Every enabled rising clock edge either loads a fresh address together with a read or write command, or advances the burst counter from the most recently loaded address. The counter follows either an XOR (interleaved) or a wrapping-add (linear) sequence, chosen by a static order pin.

Reads return data one cycle after the address is captured, for load and advance cycles alike. The data path is split into a write-data input, a read-data output and a drive-enable output. A pad ring combines them into a tri-state bus. Drive is enabled only for a selected read while the asynchronous output enable is active. An asynchronous sleep input deselects the device, releases the bus and ignores all other inputs while the stored data is kept. After sleep is released, a short guard window accepts reads and deselects but blocks writes.

Top module: `sbs_sram`

## Requirements
- R1: While reset is held low, and after it is released before any load, `rdata_oe_o` is 0 and `rdata_o` is 0.
- R2: When `clk_en_ni` is 1, a clock edge changes nothing: no byte is written, the burst position does not move, and the read data is held.
- R3: A load (`adv_i`=0) selects the device only when `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. With `rd_i`=1, `rdata_o` shows the word at `addr_i` after that edge. A load without this select deselects the device and writes nothing.
- R4: A selected load with `rd_i`=0 writes `wdata_i` at `addr_i`. Only the lanes whose `be_i` bit is 1 are written, where bit i covers data bits [8i+7:8i].
- R5: An advance (`adv_i`=1) ignores the select pins and `rd_i`. It moves the burst step forward by one from the loaded address, keeps the operation of that load, and leaves the address bits above bit 1 unchanged.
- R6: With `order_i`=1, the low two address bits on burst step k are the start bits XOR k (for example, start 01 gives 01, 00, 11, 10).
- R7: With `order_i`=0, the low two address bits on burst step k are (start + k) mod 4 (for example, start 10 gives 10, 11, 00, 01).
- R8: During a write burst, each advance writes `wdata_i` to the next burst address, updating only the lanes enabled by `be_i` on that edge.
- R9: `rdata_oe_o` is 1 only while the device is selected for a read, `oe_ni`=0 and `sleep_i`=0. It follows `oe_ni` without waiting for a clock edge. `rdata_o` is 0 whenever `rdata_oe_o` is 0.
- R10: While `sleep_i`=1, the drive enable is 0 at once, every clock edge is ignored, the device is deselected and any burst ends. Memory contents are kept.
- R11: For `WAKE_CYC` clock edges after `sleep_i` falls (2 by default), a write load writes nothing and leaves the device deselected. A read load is accepted normally.
- R12: An advance while deselected leaves the device deselected and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| adv_i | input | 1 | 1 advances the burst, 0 loads a new address |
| rd_i | input | 1 | On load: 1 read, 0 write |
| sel_a_ni | input | 1 | Select term, active low |
| sel_b_i | input | 1 | Select term, active high |
| sel_c_ni | input | 1 | Select term, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | AW | Word address |
| be_i | input | NB | Byte-lane write enables, active high |
| wdata_i | input | NB*BW | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | NB*BW | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions check, on every cycle, that the bus is released during sleep and whenever the output enable is inactive. They also check that a stalled edge writes no byte and leaves the burst position alone, that each selected advance steps the position by exactly one, and that a load without select deselects the device. A counter in the checker watches the guard window after wake-up and confirms that no lane is written inside it. Only the bench's scenarios can show the data itself: the burst address sequences in both orders, partial-byte merges, contents surviving sleep and blocked writes, and the one-cycle read latency.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;

  // low two address bits of burst step k from start s
  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] k,
                                          input logic interleave);
    return interleave ? (s ^ k) : 2'(s + k);
  endfunction
endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    step_i,
  input  logic          order_i,
  output logic [AW-1:0] addr_o
);
  assign addr_o = {base_i[AW-1:2], sbs_pkg::burst_lo(base_i[1:0], step_i, order_i)};
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int AW       = 6,
  parameter int WAKE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clk_en_ni,
  input  logic          sleep_i,
  input  logic          adv_i,
  input  logic          rd_i,
  input  logic          sel_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic          act_o,
  output logic          rd_o,
  output logic [1:0]    step_o,
  output logic          acc_en_o,
  output logic          acc_wr_o,
  output logic [AW-1:0] acc_addr_o
);
  import sbs_pkg::*;
  localparam int CW = (WAKE_CYC < 1) ? 1 : $clog2(WAKE_CYC + 1);

  logic          act_q, fire, load, blk;
  op_e           op_q;
  logic [AW-1:0] base_q, nxt_addr;
  logic [1:0]    step_q, step_nxt;
  logic [CW-1:0] wake_q;

  assign fire     = !clk_en_ni && !sleep_i;
  assign load     = !adv_i;
  assign blk      = !rd_i && (wake_q != '0);
  assign step_nxt = 2'(step_q + 2'd1);

  sbs_burst_addr #(.AW(AW)) i_baddr (
    .base_i (base_q),
    .step_i (step_nxt),
    .order_i(order_i),
    .addr_o (nxt_addr)
  );

  always_comb begin
    acc_en_o   = 1'b0;
    acc_wr_o   = 1'b0;
    acc_addr_o = nxt_addr;
    if (fire) begin
      if (load) begin
        acc_en_o   = sel_i && !blk;
        acc_wr_o   = !rd_i;
        acc_addr_o = addr_i;
      end else begin
        acc_en_o = act_q;
        acc_wr_o = (op_q == OP_WR);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      op_q   <= OP_RD;
      base_q <= '0;
      step_q <= '0;
      wake_q <= '0;
    end else if (sleep_i) begin
      act_q  <= 1'b0;
      wake_q <= CW'(WAKE_CYC);
    end else begin
      if (wake_q != '0) wake_q <= wake_q - 1'b1;
      if (fire) begin
        if (load) begin
          act_q  <= sel_i && !blk;
          op_q   <= rd_i ? OP_RD : OP_WR;
          base_q <= addr_i;
          step_q <= '0;
        end else if (act_q) begin
          step_q <= step_nxt;
        end
      end
    end
  end

  assign act_o  = act_q;
  assign rd_o   = (op_q == OP_RD);
  assign step_o = step_q;
endmodule

// File: rtl/sbs_lane.sv
module sbs_lane #(
  parameter int AW = 6,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem_q [DEPTH];
  logic [BW-1:0] dout_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (re_i) dout_q <= mem_q[addr_i];
  end

  assign rdata_o = dout_q;
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
  parameter int AW       = 6,
  parameter int NB       = 2,
  parameter int BW       = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_ni,
  input  logic             sleep_i,
  input  logic             adv_i,
  input  logic             rd_i,
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             order_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB-1:0]    be_i,
  input  logic [NB*BW-1:0] wdata_i,
  input  logic             oe_ni,
  output logic [NB*BW-1:0] rdata_o,
  output logic             rdata_oe_o
);
  localparam int DW = NB * BW;

  logic          sel, act, rd, acc_en, acc_wr;
  logic [1:0]    step;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] lane_we;
  logic [DW-1:0] dout;

  assign sel = !sel_a_ni && sel_b_i && !sel_c_ni;

  sbs_ctrl #(.AW(AW), .WAKE_CYC(WAKE_CYC)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_en_ni (clk_en_ni),
    .sleep_i   (sleep_i),
    .adv_i     (adv_i),
    .rd_i      (rd_i),
    .sel_i     (sel),
    .order_i   (order_i),
    .addr_i    (addr_i),
    .act_o     (act),
    .rd_o      (rd),
    .step_o    (step),
    .acc_en_o  (acc_en),
    .acc_wr_o  (acc_wr),
    .acc_addr_o(acc_addr)
  );

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign lane_we[l] = acc_en && acc_wr && be_i[l];
    sbs_lane #(.AW(AW), .BW(BW)) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lane_we[l]),
      .re_i   (acc_en && !acc_wr),
      .addr_i (acc_addr),
      .wdata_i(wdata_i[l*BW +: BW]),
      .rdata_o(dout[l*BW +: BW])
    );
  end

  assign rdata_oe_o = act && rd && !oe_ni && !sleep_i;
  assign rdata_o    = rdata_oe_o ? dout : '0;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
  parameter int NB       = 2,
  parameter int WAKE_CYC = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_en_ni,
  input logic          sleep_i,
  input logic          adv_i,
  input logic          sel_a_ni,
  input logic          sel_b_i,
  input logic          sel_c_ni,
  input logic          oe_ni,
  input logic          rdata_oe_o,
  input logic          act,
  input logic [1:0]    step,
  input logic [NB-1:0] lane_we
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             win_q <= '0;
    else if (sleep_i)        win_q <= CW'(WAKE_CYC);
    else if (win_q != '0)    win_q <= win_q - 1'b1;
  end

  p_stall_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |-> lane_we == '0);
  p_stall_hold_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_ni && !sleep_i) |=> $stable(step));
  p_desel_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !sleep_i && !adv_i && !(!sel_a_ni && sel_b_i && !sel_c_ni)) |=> !act);
  p_adv_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !sleep_i && adv_i && act) |=> step == 2'($past(step) + 2'd1));
  p_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!oe_ni && act));
  p_sleep_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rdata_oe_o);
  p_sleep_desel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !act);
  p_wake_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0 && !sleep_i) |-> lane_we == '0);
endmodule

bind sbs_sram sbs_sram_chk #(.NB(NB), .WAKE_CYC(WAKE_CYC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_ni (clk_en_ni),
  .sleep_i   (sleep_i),
  .adv_i     (adv_i),
  .sel_a_ni  (sel_a_ni),
  .sel_b_i   (sel_b_i),
  .sel_c_ni  (sel_c_ni),
  .oe_ni     (oe_ni),
  .rdata_oe_o(rdata_oe_o),
  .act       (act),
  .step      (step),
  .lane_we   (lane_we)
);

// File: tb/test_sbs_sram.sv
module test_sbs_sram;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        clk_en_ni, sleep_i, adv_i, rd_i, sel_a_ni, sel_b_i, sel_c_ni, order_i, oe_ni;
  logic [5:0]  addr_i;
  logic [1:0]  be_i;
  logic [15:0] wdata_i, rdata_o;
  logic        rdata_oe_o;
  logic [15:0] ref_m [64];
  int n_chk = 0, n_err = 0;

  sbs_sram i_sbs_sram (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel_ok();
    sel_a_ni = 0; sel_b_i = 1; sel_c_ni = 0;
  endtask

  task automatic load(input logic rd, input logic [5:0] a, input logic [15:0] d,
                      input logic [1:0] be);
    clk_en_ni = 0; sel_ok(); adv_i = 0; rd_i = rd; addr_i = a; wdata_i = d; be_i = be;
    tick();
  endtask

  task automatic ref_wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    if (be[0]) ref_m[a][7:0]  = d[7:0];
    if (be[1]) ref_m[a][15:8] = d[15:8];
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    load(0, a, d, be);
    ref_wr(a, d, be);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    load(1, a, 16'h0, 2'b00);
    chk(req, rdata_o, ref_m[a]);
  endtask

  task automatic adv(input logic [15:0] d, input logic [1:0] be);
    clk_en_ni = 0; adv_i = 1; wdata_i = d; be_i = be;
    sel_a_ni = 1; sel_b_i = 0; rd_i = ~rd_i;  // ignored on advance
    tick();
  endtask

  task automatic t_reset();
    chk("R1 drive in reset", {15'h0, rdata_oe_o}, 16'h0);
    rst_ni = 1; tick();
    chk("R1 drive after reset", {15'h0, rdata_oe_o}, 16'h0);
    chk("R1 data after reset", rdata_o, 16'h0);
  endtask

  task automatic t_write_read();
    wr(6'd5, 16'hA5A5, 2'b11);
    rd_chk("R3 R4 full write", 6'd5);
    chk("R9 drive on read", {15'h0, rdata_oe_o}, 16'h1);
    wr(6'd5, 16'h1234, 2'b01);
    rd_chk("R4 low lane", 6'd5);
    wr(6'd5, 16'h9900, 2'b10);
    rd_chk("R4 high lane", 6'd5);
    chk("R4 merged value", ref_m[5], 16'h9934);
  endtask

  task automatic t_burst(input logic ord, input logic [5:0] start, input string req);
    logic [1:0] lo;
    order_i = ord;
    rd_chk(req, start);
    for (int k = 1; k < 4; k++) begin
      lo = ord ? (start[1:0] ^ 2'(k)) : 2'(start[1:0] + 2'(k));
      adv(16'h0, 2'b11);
      chk({req, " R5 step"}, rdata_o, ref_m[{start[5:2], lo}]);
    end
    order_i = 1;
  endtask

  task automatic t_burst_write();
    for (int i = 16; i < 20; i++) wr(6'(i), 16'hFFFF, 2'b11);
    order_i = 1;
    wr(6'd17, 16'hD001, 2'b11);
    adv(16'hD110, 2'b10); ref_wr(6'd16, 16'hD110, 2'b10);
    adv(16'hD2D2, 2'b01); ref_wr(6'd19, 16'hD2D2, 2'b01);
    adv(16'hD333, 2'b00);
    for (int i = 16; i < 20; i++) rd_chk("R8 burst write", 6'(i));
  endtask

  task automatic t_stall();
    rd_chk("R2 setup", 6'd9);
    clk_en_ni = 1; adv_i = 1; tick(); tick();
    chk("R2 data held", rdata_o, ref_m[9]);
    adv(16'h0, 2'b11);
    chk("R2 step not moved", rdata_o, ref_m[8]);
    clk_en_ni = 1; sel_ok(); adv_i = 0; rd_i = 0; addr_i = 6'd9; wdata_i = 16'hBAD0; be_i = 2'b11;
    tick();
    rd_chk("R2 stalled write", 6'd9);
  endtask

  task automatic t_oe();
    rd_chk("R9 setup", 6'd10);
    oe_ni = 1; #1;
    chk("R9 async release", {15'h0, rdata_oe_o}, 16'h0);
    chk("R9 data zero", rdata_o, 16'h0);
    oe_ni = 0; #1;
    chk("R9 async drive", rdata_o, ref_m[10]);
  endtask

  task automatic t_deselect();
    clk_en_ni = 0; sel_ok(); sel_a_ni = 1; adv_i = 0; rd_i = 1; addr_i = 6'd9; tick();
    chk("R3 deselect", {15'h0, rdata_oe_o}, 16'h0);
    adv(16'h0, 2'b11);
    chk("R12 advance deselected", {15'h0, rdata_oe_o}, 16'h0);
    clk_en_ni = 0; sel_ok(); sel_c_ni = 1; adv_i = 0; rd_i = 0; addr_i = 6'd9;
    wdata_i = 16'hBAD1; be_i = 2'b11; tick();
    adv(16'hBAD2, 2'b11);
    rd_chk("R3 R12 no write when deselected", 6'd9);
  endtask

  task automatic t_sleep();
    rd_chk("R10 setup", 6'd9);
    #2 sleep_i = 1; #1;
    chk("R10 async release", {15'h0, rdata_oe_o}, 16'h0);
    load(0, 6'd9, 16'hBAD3, 2'b11);
    load(0, 6'd10, 16'hBAD4, 2'b11);
    sleep_i = 0;
    load(0, 6'd9, 16'hBAD5, 2'b11);
    chk("R11 write deselects", {15'h0, rdata_oe_o}, 16'h0);
    load(0, 6'd10, 16'hBAD6, 2'b11);
    rd_chk("R10 R11 contents kept", 6'd9);
    rd_chk("R10 R11 contents kept b", 6'd10);
    sleep_i = 1; tick(); sleep_i = 0;
    rd_chk("R11 read in window", 6'd8);
    adv(16'h0, 2'b11);
    chk("R11 burst after wake", rdata_o, ref_m[9]);
    wr(6'd20, 16'h0C0C, 2'b11);
    rd_chk("R11 write after window", 6'd20);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_m[i] = 16'h0;
    clk_en_ni = 0; sleep_i = 0; adv_i = 0; rd_i = 1; order_i = 1; oe_ni = 0;
    sel_a_ni = 1; sel_b_i = 0; sel_c_ni = 1; addr_i = 0; be_i = 0; wdata_i = 0;
    #(PERIOD*2);
    t_reset();
    for (int i = 0; i < 64; i++) wr(6'(i), 16'(i * 16'h0101 + 16'h1357), 2'b11);
    t_write_read();
    t_burst(1'b1, 6'd9,  "R6 interleave start 01");
    t_burst(1'b1, 6'd14, "R6 interleave start 10");
    t_burst(1'b0, 6'd10, "R7 linear start 10");
    t_burst(1'b0, 6'd27, "R7 linear start 11");
    t_burst_write();
    t_stall();
    t_oe();
    t_deselect();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD*100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule